// File: doc/BRIEF.md
# Passive I2C Bus Monitor

This block watches the two wires of an I2C bus, clock and data, using a much faster system clock. It never drives either line. It recognises the bus framing conditions, gathers each nine-bit frame and turns the bus traffic into a stream of decoded transaction events. Each event is a one-cycle strobe that carries a command code, an 8-bit payload and the acknowledge bit that closed the frame.

Both lines first pass through a synchroniser and a majority-vote glitch filter. A small state machine then walks through three phases: waiting for a start, collecting the address frame, and collecting data frames. The read/write direction from the address frame is held, and every later data byte in the transfer is tagged with it. The block keeps a flag that marks whether a stop has occurred since the last start, so that a start inside a transfer is reported as a repeated start. Only 7-bit addressing is handled.

Top module: `i2c_bus_monitor`

## Requirements
- R1: A falling edge of data while clock is high is a start condition. When no transfer is open, it produces an event with command code 0 (START). The block then collects an address frame.
- R2: In the data phase, a rising edge of data while clock is high is a stop condition. It produces an event with code 6 (STOP) and returns the block to waiting for a start.
- R3: Bits are taken on each rising clock edge. A frame is 8 bits sent most significant bit first, then an acknowledge bit that is reported in `evt_ack_o` (0 = acknowledged, 1 = not acknowledged).
- R4: The first frame after any start is an address frame. Its payload is the upper 7 bits of the byte, zero-extended. Its last bit gives the direction, 0 = write and 1 = read, and sets the code to 2 (ADDR_WR) or 3 (ADDR_RD).
- R5: Any number of data frames may follow the address frame. Each reports the full byte, with code 4 (DATA_WR) or 5 (DATA_RD) taken from the direction held from the address frame.
- R6: A start seen in the data phase, before any stop, produces code 1 (RSTART) and returns the block to address collection. A stop clears the repeated-start flag.
- R7: While the block waits for a start, clock edges and stop conditions produce no event.
- R8: During address collection, start and stop conditions are ignored. Only clock rising edges are acted on.
- R9: A start clears the bit counter and the shift register. A frame cut short by a repeated start does not affect the address frame that follows it.
- R10: A pulse on either line that lasts a single system-clock cycle is filtered out and produces no bit and no condition.
- R11: After reset nothing is reported. The first sample after reset only loads the previous-value registers, and no condition is derived from it.
- R12: START, RSTART and STOP events carry payload 0 and acknowledge 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as observed |
| sda_i | input | 1 | Bus data line as observed |
| evt_valid_o | output | 1 | One-cycle strobe for a decoded event |
| evt_cmd_o | output | 3 | Event code (0 START, 1 RSTART, 2 ADDR_WR, 3 ADDR_RD, 4 DATA_WR, 5 DATA_RD, 6 STOP) |
| evt_data_o | output | 8 | Address (7-bit, zero-extended) or data byte |
| evt_ack_o | output | 1 | Acknowledge bit of the frame, 1 = not acknowledged |

## Verification
The assertions assume that the bus changes data only while clock is low, except when it forms a start or stop. They also assume that each wire holds its level for several system cycles, so the filter passes every real transition, and that the lines sit high through reset. The stimulus sets data only in the low phase of the clock and holds every level for eight cycles. It breaks the rule on purpose in only two places: single-cycle glitches, which the filter must absorb, and start/stop patterns during address collection, which the state machine must ignore.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    typedef enum logic [2:0] {
        CMD_START   = 3'd0,
        CMD_RSTART  = 3'd1,
        CMD_ADDR_WR = 3'd2,
        CMD_ADDR_RD = 3'd3,
        CMD_DATA_WR = 3'd4,
        CMD_DATA_RD = 3'd5,
        CMD_STOP    = 3'd6
    } mon_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } mon_state_e;

    typedef struct packed {
        logic     valid;
        mon_cmd_e cmd;
        logic [7:0] data;
        logic     ack;
    } mon_event_t;

    typedef struct packed {
        logic scl_rise;
        logic start;
        logic stop;
        logic sda;
    } bus_cond_t;

    function automatic mon_cmd_e frame_cmd(input logic is_addr, input logic rd);
        if (is_addr) return rd ? CMD_ADDR_RD : CMD_ADDR_WR;
        return rd ? CMD_DATA_RD : CMD_DATA_WR;
    endfunction

endpackage

// File: rtl/i2cmon_line_cond.sv
module i2cmon_line_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    localparam int HALF = FILT_TAPS / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_TAPS-1:0]   win_q;
    logic                   filt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            win_q  <= '1;
            filt_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            win_q  <= {win_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
            filt_q <= ($countones(win_q) > HALF);
        end
    end

    assign line_o = filt_q;
endmodule

// File: rtl/i2cmon_cond_detect.sv
module i2cmon_cond_detect
    import i2cmon_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl,
    input  logic      sda,
    output bus_cond_t cond_o
);
    logic primed_q;
    logic scl_prev_q;
    logic sda_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            primed_q   <= 1'b0;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            primed_q   <= 1'b1;
            scl_prev_q <= scl;
            sda_prev_q <= sda;
        end
    end

    always_comb begin
        cond_o.scl_rise = primed_q && !scl_prev_q && scl;
        cond_o.start    = primed_q && sda_prev_q && !sda && scl;
        cond_o.stop     = primed_q && !sda_prev_q && sda && scl;
        cond_o.sda      = sda;
    end
endmodule

// File: rtl/i2cmon_frame_fsm.sv
module i2cmon_frame_fsm
    import i2cmon_pkg::*;
#(
    parameter int FRAME_BITS = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_cond_t  cond_i,
    output mon_event_t evt_o,
    output mon_state_e state_o
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    mon_state_e            st_q;
    logic [CNT_W-1:0]      cnt_q;
    logic [FRAME_BITS-2:0] sh_q;
    logic                  rep_q;
    logic                  rd_q;
    mon_event_t            evt_q;

    logic [FRAME_BITS-1:0] sh_next;
    logic [7:0]            frame_byte;
    logic                  frame_done;

    always_comb begin
        sh_next    = {sh_q, cond_i.sda};
        frame_byte = sh_next[FRAME_BITS-1:1];
        frame_done = (cnt_q == LAST_BIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            sh_q  <= '0;
            rep_q <= 1'b0;
            rd_q  <= 1'b0;
            evt_q <= '0;
        end else begin
            evt_q.valid <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (cond_i.start) begin
                        evt_q <= '{valid: 1'b1,
                                   cmd: rep_q ? CMD_RSTART : CMD_START,
                                   data: 8'h00, ack: 1'b0};
                        st_q  <= ST_ADDR;
                        cnt_q <= '0;
                        sh_q  <= '0;
                        rep_q <= 1'b1;
                    end
                end
                ST_ADDR: begin
                    if (cond_i.scl_rise) begin
                        if (frame_done) begin
                            evt_q <= '{valid: 1'b1,
                                       cmd: frame_cmd(1'b1, frame_byte[0]),
                                       data: {1'b0, frame_byte[7:1]},
                                       ack: cond_i.sda};
                            rd_q  <= frame_byte[0];
                            st_q  <= ST_DATA;
                            cnt_q <= '0;
                            sh_q  <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                            sh_q  <= sh_next[FRAME_BITS-2:0];
                        end
                    end
                end
                ST_DATA: begin
                    if (cond_i.scl_rise) begin
                        if (frame_done) begin
                            evt_q <= '{valid: 1'b1,
                                       cmd: frame_cmd(1'b0, rd_q),
                                       data: frame_byte,
                                       ack: cond_i.sda};
                            cnt_q <= '0;
                            sh_q  <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                            sh_q  <= sh_next[FRAME_BITS-2:0];
                        end
                    end else if (cond_i.start) begin
                        evt_q <= '{valid: 1'b1,
                                   cmd: rep_q ? CMD_RSTART : CMD_START,
                                   data: 8'h00, ack: 1'b0};
                        st_q  <= ST_ADDR;
                        cnt_q <= '0;
                        sh_q  <= '0;
                        rep_q <= 1'b1;
                    end else if (cond_i.stop) begin
                        evt_q <= '{valid: 1'b1, cmd: CMD_STOP,
                                   data: 8'h00, ack: 1'b0};
                        st_q  <= ST_IDLE;
                        rep_q <= 1'b0;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign evt_o   = evt_q;
    assign state_o = st_q;
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 3,
    parameter int FRAME_BITS  = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       evt_valid_o,
    output logic [2:0] evt_cmd_o,
    output logic [7:0] evt_data_o,
    output logic       evt_ack_o
);
    localparam int NUM_LINES = 2;

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] clean_lines;
    bus_cond_t            cond;
    mon_event_t           evt;
    mon_state_e           st;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        i2cmon_line_cond #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_TAPS  (FILT_TAPS)
        ) u_cond (
            .clk   (clk),
            .rst   (rst),
            .line_i(raw_lines[g]),
            .line_o(clean_lines[g])
        );
    end

    i2cmon_cond_detect u_detect (
        .clk   (clk),
        .rst   (rst),
        .scl   (clean_lines[0]),
        .sda   (clean_lines[1]),
        .cond_o(cond)
    );

    i2cmon_frame_fsm #(.FRAME_BITS(FRAME_BITS)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .cond_i (cond),
        .evt_o  (evt),
        .state_o(st)
    );

    assign evt_valid_o = evt.valid;
    assign evt_cmd_o   = evt.cmd;
    assign evt_data_o  = evt.data;
    assign evt_ack_o   = evt.ack;
endmodule

// File: rtl/i2c_bus_monitor_chk.sv
module i2c_bus_monitor_chk
    import i2cmon_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       evt_valid,
    input logic [2:0] evt_cmd,
    input logic [7:0] evt_data,
    input logic       evt_ack,
    input mon_state_e st,
    input bus_cond_t  cond
);
    // R1, R4, R5, R6, R2: only defined codes appear
    a_r1_code_range: assert property (@(posedge clk) disable iff (rst)
        evt_valid |-> evt_cmd <= 3'd6);

    // R12: framing events carry no payload
    a_r12_frame_events_empty: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && (evt_cmd == 3'd0 || evt_cmd == 3'd1 || evt_cmd == 3'd6))
        |-> (evt_data == 8'h00 && !evt_ack));

    // R4: address payload is 7 bits wide and the block moves to data phase
    a_r4_addr_payload: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && (evt_cmd == 3'd2 || evt_cmd == 3'd3))
        |-> (!evt_data[7] && st == ST_DATA));

    // R2: a stop event leaves the block waiting for a start
    a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_cmd == 3'd6) |-> st == ST_IDLE);

    // R1, R6: any start event puts the block into address collection
    a_r6_start_to_addr: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_cmd <= 3'd1) |-> st == ST_ADDR);

    // R7: no frame event follows a cycle spent waiting for a start
    a_r7_idle_silent: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |=> !(evt_valid && evt_cmd >= 3'd2 && evt_cmd <= 3'd6));

    // R11: the first sample after reset yields no condition
    a_r11_first_sample: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !(cond.scl_rise || cond.start || cond.stop));
endmodule

bind i2c_bus_monitor i2c_bus_monitor_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt_valid(evt_valid_o),
    .evt_cmd  (evt_cmd_o),
    .evt_data (evt_data_o),
    .evt_ack  (evt_ack_o),
    .st       (st),
    .cond     (cond)
);

// File: tb/i2c_bus_monitor_tb.sv
module i2c_bus_monitor_tb;
    localparam int H = 8;

    typedef struct {
        logic [2:0] cmd;
        logic [7:0] data;
        logic       ack;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       evt_valid;
    logic [2:0] evt_cmd;
    logic [7:0] evt_data;
    logic       evt_ack;

    int checks = 0;
    int errors = 0;
    int seen   = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    i2c_bus_monitor u_dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
        .evt_valid_o(evt_valid), .evt_cmd_o(evt_cmd),
        .evt_data_o(evt_data), .evt_ack_o(evt_ack)
    );

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && evt_valid) begin
            seen++;
            checks++;
            if (q.size() == 0) begin
                errors++;
                $display("FAIL unexpected event: actual cmd=%0d data=%h ack=%b, expected none",
                         evt_cmd, evt_data, evt_ack);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (evt_cmd !== e.cmd || evt_data !== e.data || evt_ack !== e.ack) begin
                    errors++;
                    $display("FAIL %s: actual cmd=%0d data=%h ack=%b, expected cmd=%0d data=%h ack=%b",
                             e.req, evt_cmd, evt_data, evt_ack, e.cmd, e.data, e.ack);
                end
            end
        end
    end

    task automatic expect_evt(input logic [2:0] c, input logic [7:0] d,
                              input logic a, input string r);
        exp_t e;
        e.cmd = c; e.data = d; e.ack = a; e.req = r;
        q.push_back(e);
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sda = b; hold(H);
        scl = 1'b1; hold(H);
        scl = 1'b0; hold(H);
    endtask

    task automatic byte_out(input logic [7:0] b, input logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_out(ack);
    endtask

    task automatic glitchy_byte(input logic [7:0] b, input logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda = b[i]; hold(H);
            scl = 1'b1; hold(1); scl = 1'b0; hold(H);
            scl = 1'b1; hold(H);
            sda = ~b[i]; hold(1); sda = b[i]; hold(H);
            scl = 1'b0; hold(H);
        end
        bit_out(ack);
    endtask

    task automatic bus_start();
        sda = 1'b0; hold(H);
        scl = 1'b0; hold(H);
    endtask

    task automatic bus_rstart();
        sda = 1'b1; hold(H);
        scl = 1'b1; hold(H);
        sda = 1'b0; hold(H);
        scl = 1'b0; hold(H);
    endtask

    task automatic bus_stop();
        sda = 1'b0; hold(H);
        scl = 1'b1; hold(H);
        sda = 1'b1; hold(H);
    endtask

    task automatic check_count(input int exp_seen, input string r);
        checks++;
        if (seen != exp_seen) begin
            errors++;
            $display("FAIL %s: actual events=%0d expected=%0d", r, seen, exp_seen);
        end
    endtask

    task automatic run();
        hold(5);
        rst = 1'b0;
        hold(20);
        // R11: quiet after reset
        checks++;
        if (evt_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11: actual valid=%b expected 0", evt_valid);
        end
        check_count(0, "R11");

        // R7: clock pulses and a stop pattern while waiting
        scl = 1'b0; hold(H);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_stop();
        hold(H);
        check_count(0, "R7");

        // R1 R3 R4 R5 R2: write transfer
        expect_evt(3'd0, 8'h00, 1'b0, "R1 start");
        bus_start();
        expect_evt(3'd2, 8'h50, 1'b0, "R4 addr write");
        byte_out(8'hA0, 1'b0);
        expect_evt(3'd4, 8'h3C, 1'b0, "R5 data write");
        byte_out(8'h3C, 1'b0);
        expect_evt(3'd4, 8'hFF, 1'b1, "R3 nack");
        byte_out(8'hFF, 1'b1);
        expect_evt(3'd6, 8'h00, 1'b0, "R2 stop");
        bus_stop();
        hold(H);

        // R4 R5 R6: read transfer then repeated start
        expect_evt(3'd0, 8'h00, 1'b0, "R6 start after stop");
        bus_start();
        expect_evt(3'd3, 8'h2B, 1'b0, "R4 addr read");
        byte_out(8'h57, 1'b0);
        expect_evt(3'd5, 8'h81, 1'b0, "R5 data read");
        byte_out(8'h81, 1'b0);
        expect_evt(3'd5, 8'h00, 1'b1, "R5 data read nack");
        byte_out(8'h00, 1'b1);
        expect_evt(3'd1, 8'h00, 1'b0, "R6 rstart");
        bus_rstart();
        expect_evt(3'd2, 8'h7F, 1'b1, "R6 addr after rstart");
        byte_out(8'hFE, 1'b1);
        expect_evt(3'd4, 8'h5A, 1'b0, "R6 data write dir");
        byte_out(8'h5A, 1'b0);
        expect_evt(3'd6, 8'h00, 1'b0, "R2 stop");
        bus_stop();
        hold(H);

        // R8: stop and start patterns during address collection
        expect_evt(3'd0, 8'h00, 1'b0, "R8 start");
        bus_start();
        sda = 1'b0; hold(H);
        scl = 1'b1; hold(H);
        sda = 1'b1; hold(H);
        sda = 1'b0; hold(H);
        scl = 1'b0; hold(H);
        expect_evt(3'd2, 8'h1A, 1'b0, "R8 addr unaffected");
        for (int i = 6; i >= 0; i--) bit_out(8'h34 >> i);
        bit_out(1'b0);
        expect_evt(3'd6, 8'h00, 1'b0, "R2 stop");
        bus_stop();
        hold(H);

        // R9: repeated start cuts a data frame short
        expect_evt(3'd0, 8'h00, 1'b0, "R9 start");
        bus_start();
        expect_evt(3'd2, 8'h48, 1'b0, "R9 addr");
        byte_out(8'h90, 1'b0);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        expect_evt(3'd1, 8'h00, 1'b0, "R9 rstart");
        bus_rstart();
        expect_evt(3'd3, 8'h50, 1'b0, "R9 addr after partial frame");
        byte_out(8'hA1, 1'b0);
        expect_evt(3'd5, 8'h66, 1'b1, "R9 data read");
        byte_out(8'h66, 1'b1);
        expect_evt(3'd6, 8'h00, 1'b0, "R2 stop");
        bus_stop();
        hold(H);

        // R10: single-cycle glitches on both lines
        expect_evt(3'd0, 8'h00, 1'b0, "R10 start");
        bus_start();
        expect_evt(3'd2, 8'h42, 1'b0, "R10 addr");
        byte_out(8'h84, 1'b0);
        expect_evt(3'd4, 8'hC3, 1'b0, "R10 glitch byte");
        glitchy_byte(8'hC3, 1'b0);
        expect_evt(3'd6, 8'h00, 1'b0, "R12 stop");
        bus_stop();
        hold(4 * H);
    endtask

    initial begin
        bit timed_out = 1'b0;
        fork
            run();
            begin
                repeat (150000) @(negedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout, expected completion");
        end
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R1-R12 pending: actual %0d missing events, expected 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule